// File: doc/BRIEF.md
# Run-Limited Pseudo-Random Pattern Source and Bit-Error Counter

This block exercises a slow serial link, such as an optical downlink looped back to its own receiver. A pulse on `start` begins a measurement. The block then sends a pseudo-random bit pattern on `tx_line`. The pattern comes from an 8-bit maximal-length shift register and passes through a run-length limiter, so no more than four equal bits are ever sent in a row. Each bit stays on the line for `BIT_CYCLES` system-clock cycles. With the default 2500 cycles at 50 MHz, that is a 50 us bit and a 20 kb/s rate.

The far end returns the pattern on `rx_line` after a fixed delay of `LATENCY_CYCLES` clock cycles. The block does not delay the received signal. Instead it starts a second, identical pattern source that many cycles after the transmit source, so the local copy lines up with the returning stream. At the middle cycle of every aligned bit slot, the block samples `rx_line` and compares it with the local copy. It counts the bits compared and the mismatches. When `RUN_BITS` bits have been compared, the run ends.

The line is a timed serial signal, not a stream. It has no valid/ready handshake and cannot be back-pressured: every bit slot is sent and sampled on schedule. Control and status pins are plain levels.

Top module: `prbs_link_tester`

## Requirements
- R1: The pattern state is an 8-bit shift register.
  - Each step shifts it left by one bit.
  - The new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1).
  - The raw output bit is bit 7.
  - On reset and at every idle-to-run change, the state is loaded with the nonzero `SEED`, and the first slot carries `SEED[7]`.
  - The state never becomes all zero.
- R2: After four slots carrying the same bit, the next slot carries the complement of that bit, and the shift register does not step for that slot. Otherwise each slot carries the next raw bit and the register steps once. Therefore `tx_line` never holds the same value for more than four consecutive slots.
- R3: While `busy` is high, each slot lasts exactly `BIT_CYCLES` cycles. While `busy` is low, `tx_line` is 0.
- R4: The block accepts a `start` pulse only while `busy` is low. On the clock edge that samples it:
  - `busy` goes high and `done` goes low;
  - both counts clear;
  - the first transmit slot begins in the cycle after that edge.
- R5: The local copy of the pattern begins `LATENCY_CYCLES` cycles after the first transmit slot.
  - `rx_line` is sampled in cycle `BIT_CYCLES/2` of each local slot, counting from 0.
  - Each sample increments `bit_count`.
  - A sample that differs from the local bit increments `err_count`.
- R6: `err_count` stops at 2^`ERR_W`-1 and holds that value for the rest of the run.
- R7: The sample that brings `bit_count` to `RUN_BITS` has these effects:
  - `done` goes high and `busy` goes low in the following cycle;
  - `tx_line` drops to 0;
  - both counts hold until the next accepted `start`.
- R8: A `start` pulse while `busy` is high has no effect. The run continues and finishes as if the pulse never came.
- R9: After reset, `busy`, `done`, `tx_line`, `bit_count` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a measurement |
| tx_line | output | 1 | Outgoing pattern bit |
| rx_line | input | 1 | Returned bit stream |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Run complete; counts are final |
| bit_count | output | CNT_W | Number of bits compared |
| err_count | output | ERR_W | Number of mismatches (saturating) |

## Verification
Three events can fall in the same clock cycle: the final compared bit of a run, an error on that bit, and, when errors are plentiful, the error counter reaching its ceiling. The bench corrupts every seventh returned bit slot, with the final slot of the run chosen as one of them, so the last comparison is both an error and the end of the run. A second run inverts every returned bit, so the counter saturates long before the final bit, which is again a mismatch. In both runs the bench checks the exact error total, the exact cycle in which `done` rises, and that the counts stay frozen afterwards.

// File: rtl/prbs_tst_pkg.sv
package prbs_tst_pkg;
  localparam int PAT_W   = 8;
  localparam int MAX_RUN = 4;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  function automatic logic [PAT_W-1:0] pat_step(input logic [PAT_W-1:0] s);
    return {s[PAT_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/rll_pattern_gen.sv
module rll_pattern_gen
  import prbs_tst_pkg::*;
#(
  parameter int               BIT_CYCLES = 2500,
  parameter logic [PAT_W-1:0] SEED       = 8'hA5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_o,
  output logic mid_o,
  output logic last_o
);
  localparam int CYC_W = $clog2(BIT_CYCLES + 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BIT_CYCLES - 1);
  localparam logic [CYC_W-1:0] MID_CYC  = CYC_W'(BIT_CYCLES / 2);
  localparam logic [RUN_W-1:0] RUN_CAP  = RUN_W'(MAX_RUN);

  logic [PAT_W-1:0] state_q;
  logic             bit_q;
  logic [RUN_W-1:0] run_q;
  logic [CYC_W-1:0] cyc_q;
  logic             raw_bit;

  assign raw_bit = state_q[PAT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= pat_step(SEED);
      bit_q   <= SEED[PAT_W-1];
      run_q   <= RUN_W'(1);
      cyc_q   <= '0;
    end else if (!run) begin
      state_q <= pat_step(SEED);
      bit_q   <= SEED[PAT_W-1];
      run_q   <= RUN_W'(1);
      cyc_q   <= '0;
    end else if (cyc_q == LAST_CYC) begin
      cyc_q <= '0;
      if (run_q == RUN_CAP) begin
        bit_q <= ~bit_q;
        run_q <= RUN_W'(1);
      end else begin
        bit_q   <= raw_bit;
        state_q <= pat_step(state_q);
        run_q   <= (raw_bit == bit_q) ? run_q + RUN_W'(1) : RUN_W'(1);
      end
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign bit_o  = bit_q;
  assign mid_o  = run && (cyc_q == MID_CYC);
  assign last_o = run && (cyc_q == LAST_CYC);
endmodule

// File: rtl/ber_tally.sv
module ber_tally #(
  parameter int RUN_BITS = 1000000,
  parameter int CNT_W    = 20,
  parameter int ERR_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             miss,
  output logic [CNT_W-1:0] bit_count,
  output logic [ERR_W-1:0] err_count,
  output logic             final_bit
);
  localparam logic [ERR_W-1:0] ERR_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RUN_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_count <= '0;
      err_count <= '0;
    end else if (clear) begin
      bit_count <= '0;
      err_count <= '0;
    end else if (sample) begin
      bit_count <= bit_count + CNT_W'(1);
      if (miss && err_count != ERR_MAX) err_count <= err_count + ERR_W'(1);
    end
  end

  assign final_bit = sample && (bit_count == LAST_IDX);
endmodule

// File: rtl/prbs_link_tester.sv
module prbs_link_tester
  import prbs_tst_pkg::*;
#(
  parameter int               BIT_CYCLES     = 2500,
  parameter int               LATENCY_CYCLES = 2000,
  parameter int               RUN_BITS       = 1000000,
  parameter int               ERR_W          = 16,
  parameter int               CNT_W          = $clog2(RUN_BITS + 1),
  parameter logic [PAT_W-1:0] SEED           = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             tx_line,
  input  logic             rx_line,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bit_count,
  output logic [ERR_W-1:0] err_count
);
  localparam int LAT_W = $clog2(LATENCY_CYCLES + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATENCY_CYCLES - 1);

  logic             busy_q, done_q, rx_run_q;
  logic [LAT_W-1:0] lat_q;
  logic             accept, fin;
  logic             tx_bit, tx_mid, tx_last;
  logic             rx_bit, rx_mid, rx_last;

  assign accept = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rx_run_q <= 1'b0;
      lat_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      rx_run_q <= 1'b0;
      lat_q    <= '0;
    end else if (busy_q) begin
      if (fin) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        rx_run_q <= 1'b0;
      end else if (!rx_run_q) begin
        if (lat_q == LAT_LAST) rx_run_q <= 1'b1;
        else                   lat_q    <= lat_q + LAT_W'(1);
      end
    end
  end

  rll_pattern_gen #(.BIT_CYCLES(BIT_CYCLES), .SEED(SEED)) i_tx_gen (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .bit_o(tx_bit), .mid_o(tx_mid), .last_o(tx_last)
  );

  rll_pattern_gen #(.BIT_CYCLES(BIT_CYCLES), .SEED(SEED)) i_rx_gen (
    .clk(clk), .rst_n(rst_n), .run(rx_run_q),
    .bit_o(rx_bit), .mid_o(rx_mid), .last_o(rx_last)
  );

  ber_tally #(.RUN_BITS(RUN_BITS), .CNT_W(CNT_W), .ERR_W(ERR_W)) i_tally (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(rx_mid),
    .miss(rx_line != rx_bit), .bit_count(bit_count), .err_count(err_count),
    .final_bit(fin)
  );

  assign tx_line = busy_q & tx_bit;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/prbs_link_tester_chk.sv
module prbs_link_tester_chk
  import prbs_tst_pkg::*;
#(
  parameter int RUN_BITS = 1000000,
  parameter int CNT_W    = 20,
  parameter int ERR_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             tx_line,
  input logic             tx_mid,
  input logic             tx_last,
  input logic             rx_run,
  input logic             rx_mid,
  input logic             rx_last,
  input logic [PAT_W-1:0] tx_state,
  input logic [CNT_W-1:0] bit_count,
  input logic [ERR_W-1:0] err_count
);
  localparam logic [ERR_W-1:0]   ERR_MAX = '1;
  localparam logic [MAX_RUN-1:0] ALL1    = '1;

  logic [MAX_RUN-1:0] hist_q;
  logic [RUN_W-1:0]   hcnt_q;
  logic [1:0]         slot_samples_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      hcnt_q <= '0;
    end else if (!busy) begin
      hcnt_q <= '0;
    end else if (tx_last) begin
      hist_q <= {hist_q[MAX_RUN-2:0], tx_line};
      if (hcnt_q != RUN_W'(MAX_RUN)) hcnt_q <= hcnt_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot_samples_q <= '0;
    else if (!rx_run || rx_last) slot_samples_q <= '0;
    else if (rx_mid)             slot_samples_q <= slot_samples_q + 2'd1;
  end

  a_r1_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state != '0);
  a_r2_no_fifth_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hcnt_q == RUN_W'(MAX_RUN) && hist_q == ALL1) |-> !tx_line);
  a_r2_no_fifth_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hcnt_q == RUN_W'(MAX_RUN) && hist_q == '0) |-> tx_line);
  a_r3_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_line);
  a_r3_mid_slot_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mid && $past(busy)) |-> tx_line == $past(tx_line));
  a_r5_one_sample_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mid |-> slot_samples_q == 2'd0);
  a_r5_errors_within_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ERR_W >= CNT_W || err_count == ERR_MAX || CNT_W'(err_count) <= bit_count);
  a_r6_err_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX && !start) |=> err_count == ERR_MAX);
  a_r7_done_at_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> bit_count == CNT_W'(RUN_BITS));
  a_r7_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> ($stable(bit_count) || bit_count != '0));
endmodule

bind prbs_link_tester prbs_link_tester_chk #(
  .RUN_BITS(RUN_BITS), .CNT_W(CNT_W), .ERR_W(ERR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tx_line(tx_line), .tx_mid(tx_mid), .tx_last(tx_last),
  .rx_run(rx_run_q), .rx_mid(rx_mid), .rx_last(rx_last),
  .tx_state(i_tx_gen.state_q), .bit_count(bit_count), .err_count(err_count)
);

// File: tb/test_prbs_link_tester.sv
module test_prbs_link_tester;
  localparam int B      = 8;
  localparam int L      = 5;
  localparam int NB     = 600;
  localparam int EW     = 8;
  localparam int CW     = $clog2(NB + 1);
  localparam logic [7:0] SEED = 8'hA5;
  localparam int DONE_AT = L + (NB - 1) * B + B / 2 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tx_line, rx_line, busy, done;
  logic [CW-1:0] bit_count;
  logic [EW-1:0] err_count;

  int tests = 0;
  int fails = 0;
  int rel = 0;
  int mode = 0;
  int cycles = 0;
  int obs_run = 0;
  logic obs_prev = 1'b0;
  logic [L-1:0] dly = '0;
  logic exp_bits [NB];
  logic flip;

  always #10 clk = ~clk;

  prbs_link_tester #(
    .BIT_CYCLES(B), .LATENCY_CYCLES(L), .RUN_BITS(NB), .ERR_W(EW), .SEED(SEED)
  ) i_prbs_link_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_line(tx_line),
    .rx_line(rx_line), .busy(busy), .done(done),
    .bit_count(bit_count), .err_count(err_count)
  );

  assign flip = (mode == 2) ||
                (mode == 1 && rel >= L && (((rel - L) / B) % 7) == 4);
  assign rx_line = dly[L-1] ^ flip;

  always @(posedge clk) begin
    dly <= {dly[L-2:0], tx_line};
    if (start && !busy) rel <= 0;
    else                rel <= rel + 1;
    cycles <= cycles + 1;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1, R2, R3: every transmitted slot compared at mid-slot with the arithmetic model
  always @(negedge clk) begin
    if (rst_n && busy && (rel % B) == B / 2 && rel / B < NB) begin
      check(tx_line == exp_bits[rel / B], "R1 pattern bit", tx_line, exp_bits[rel / B]);
      if (rel / B == 0 || tx_line != obs_prev) obs_run = 1;
      else obs_run++;
      obs_prev = tx_line;
      check(obs_run <= 4, "R2 run length", obs_run, 4);
    end
  end

  function automatic logic [7:0] stepf(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic build_model();
    logic [7:0] s;
    logic cur;
    int rl;
    s = SEED; cur = s[7]; s = stepf(s); rl = 1;
    exp_bits[0] = cur;
    for (int k = 1; k < NB; k++) begin
      if (rl == 4) begin
        cur = ~cur; rl = 1;
      end else begin
        rl = (s[7] == cur) ? rl + 1 : 1;
        cur = s[7];
        s = stepf(s);
      end
      exp_bits[k] = cur;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int at);
    at = -1;
    while (!done && cycles < 150000) @(negedge clk);
    at = rel;
  endtask

  task automatic do_run(input int m, input int exp_err, input string tag, input bit poke);
    int at;
    mode = m;
    pulse_start();
    check(busy && !done, "R4 busy after start", busy, 1);
    check(bit_count == 0 && err_count == 0, "R4 counts cleared", bit_count, 0);
    if (poke) begin
      repeat (200 * B) @(negedge clk);
      pulse_start();
      check(busy, "R8 busy kept", busy, 1);
    end
    wait_done(at);
    check(at == DONE_AT, {tag, " R5 R7 done cycle"}, at, DONE_AT);
    check(bit_count == NB, {tag, " R7 bit count"}, bit_count, NB);
    check(err_count == exp_err, {tag, " R5 R6 error count"}, err_count, exp_err);
    check(!busy && !tx_line, {tag, " R7 idle after run"}, tx_line, 0);
    repeat (3 * B) @(negedge clk);
    check(done && bit_count == NB && err_count == exp_err, {tag, " R7 counts hold"},
          err_count, exp_err);
  endtask

  initial begin
    build_model();
    repeat (3) @(negedge clk);
    check(!busy && !done && !tx_line && bit_count == 0 && err_count == 0,
          "R9 reset state", {busy, done, tx_line}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !tx_line, "R3 idle line", tx_line, 0);
    do_run(0, 0, "clean+R8", 1'b1);
    do_run(1, ((NB - 1 - 4) / 7) + 1, "sparse", 1'b0);
    do_run(2, (1 << EW) - 1, "inverted", 1'b0);
    check(cycles < 150000, "watchdog", cycles, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3200000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule